// File: doc/BRIEF.md
# Asynchronous NAND Flash Strobe Sequencer

This block drives an 8-bit asynchronous NAND flash port. A host issues one request at a time. Each request carries a direction flag, a two-bit cycle selector that marks the cycle as command, address or plain data, and a write byte. The block turns the request into a chip-enable window that holds the command-latch and address-latch lines steady. Inside that window it runs a setup phase, a write or read strobe, and a hold phase. On reads it captures the byte the flash returns and presents it together with a one-cycle completion pulse.

Every phase length comes from one packed 32-bit timing word, with separate setup, strobe and hold fields for each direction. The sequencer latches the relevant fields when it accepts a request. When the direction reverses between two accesses, it adds an idle gap of programmable length so the data bus can change hands. The flash ready/busy pin passes through a flop synchroniser and comes out as a status bit.

Top module: `nand_strobe_seq`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `nand_ce_n`, `nand_we_n` and `nand_re_n` are 1, and `nand_cle`, `nand_ale`, `nand_doe`, `busy` and `done` are 0. Whenever chip-enable is high, the latch lines and the output enable are low.
- R2: Write phase lengths come from `cfg_word`, each lasting its field value plus one cycle. Setup is bits 29:26, strobe is bits 25:20 and hold is bits 19:17. Chip-enable falls at the start of setup and rises at the end of hold. `nand_we_n` is low exactly during the strobe.
- R3: Read phase lengths come from `cfg_word` in the same way. Setup is bits 16:13, strobe is bits 12:7 and hold is bits 6:4. `nand_re_n` is low exactly during the strobe.
- R4: On a read, `rdata` holds the `nand_din` value sampled on the last clock of the read strobe. It is valid when `done` pulses.
- R5: On a write, `nand_dout` carries `req_wdata` and `nand_doe` is 1 for the whole chip-enable window.
- R6: `req_sel` bit 0 asserts `nand_cle` and bit 1 asserts `nand_ale`. If both are set, only `nand_cle` is asserted. Both lines are cleared between accesses and stay constant within one access.
- R7: The turnaround field is bits 3:2. When an access follows one of the opposite direction, chip-enable stays high for the turnaround value plus two cycles between them. It stays high for one cycle when the direction is the same. No gap is inserted before the first access after reset.
- R8: `done` pulses for one cycle, starting in the cycle after the hold phase ends. `busy` is 1 from the cycle after acceptance until `done`. A request is accepted when `req_valid` is 1 and `busy` is 0.
- R9: `dev_ready` follows `nand_rdy` through two flops. A change sampled at one clock edge appears after the second edge. A value of 1 means ready.
- R10: Bits 31 and 30 and the size field, bits 1:0, have no effect on timing. Only the 8-bit bus is supported.
- R11: `nand_we_n` and `nand_re_n` are never low together and never low while `nand_ce_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_word | input | 32 | Packed timing word |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | 2 | Bit 0 command cycle, bit 1 address cycle |
| req_wdata | input | 8 | Write byte |
| busy | output | 1 | Access or gap in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Captured read byte |
| dev_ready | output | 1 | Synchronised ready status |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dout | output | 8 | Data to flash |
| nand_doe | output | 1 | Data output enable |
| nand_din | input | 8 | Data from flash |
| nand_rdy | input | 1 | Raw ready/busy pin |

## Verification
The bench measures, at the pins, the length of every setup, strobe and hold phase. It uses a zero timing word, the example programming and a near-maximum word, so a design that reads a field at the wrong offset or drops the "+1" gives the wrong cycle counts. It issues back-to-back accesses with mixed directions. A design that inserts the turnaround on every access, never inserts it, or inserts it before the first access after reset shows the wrong chip-enable gap.

The flash model returns data only while the read strobe is low, so a capture on the wrong cycle returns zero. Requests with both selector bits set catch a design that raises both latch lines. Stepping the ready pin catches a synchroniser with the wrong depth.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
  localparam int SETUP_W  = 4;
  localparam int STROBE_W = 6;
  localparam int HOLD_W   = 3;
  localparam int TURN_W   = 2;
  localparam int CNT_W    = STROBE_W;

  localparam int WSETUP_LSB  = 26;
  localparam int WSTROBE_LSB = 20;
  localparam int WHOLD_LSB   = 17;
  localparam int RSETUP_LSB  = 13;
  localparam int RSTROBE_LSB = 7;
  localparam int RHOLD_LSB   = 4;
  localparam int TURN_LSB    = 2;

  typedef struct packed {
    logic [SETUP_W-1:0]  setup;
    logic [STROBE_W-1:0] strobe;
    logic [HOLD_W-1:0]   hold;
  } acc_timing_t;

  typedef enum logic [2:0] {
    PH_IDLE, PH_TURN, PH_SETUP, PH_STROBE, PH_HOLD
  } phase_e;
endpackage

// File: rtl/nand_cfg_decode.sv
module nand_cfg_decode
  import nand_seq_pkg::*;
(
  input  logic [31:0]       cfg_word,
  output acc_timing_t       wr_t,
  output acc_timing_t       rd_t,
  output logic [TURN_W-1:0] turn
);
  assign wr_t.setup  = cfg_word[WSETUP_LSB  +: SETUP_W];
  assign wr_t.strobe = cfg_word[WSTROBE_LSB +: STROBE_W];
  assign wr_t.hold   = cfg_word[WHOLD_LSB   +: HOLD_W];
  assign rd_t.setup  = cfg_word[RSETUP_LSB  +: SETUP_W];
  assign rd_t.strobe = cfg_word[RSTROBE_LSB +: STROBE_W];
  assign rd_t.hold   = cfg_word[RHOLD_LSB   +: HOLD_W];
  assign turn        = cfg_word[TURN_LSB    +: TURN_W];
endmodule

// File: rtl/nand_rdy_sync.sv
module nand_rdy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= 1'b0;
    else     chain[0] <= din;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[g] <= 1'b0;
      else     chain[g] <= chain[g-1];
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/nand_phase_ctrl.sv
module nand_phase_ctrl
  import nand_seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  acc_timing_t       wr_t,
  input  acc_timing_t       rd_t,
  input  logic [TURN_W-1:0] turn,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_sel,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] nand_din,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              nand_ce_n,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic [DATA_W-1:0] nand_dout,
  output logic              nand_doe
);
  phase_e              state, state_d;
  logic [CNT_W-1:0]    cnt, cnt_d;
  acc_timing_t         cur_t, sel_t;
  logic                op_write, op_cle, op_ale;
  logic [DATA_W-1:0]   op_wdata;
  logic                have_prev, last_write;
  logic                accept, in_acc_d, wr_d, cle_d, ale_d;
  logic [DATA_W-1:0]   wdata_d;

  assign accept = (state == PH_IDLE) && req_valid;
  assign sel_t  = req_write ? wr_t : rd_t;

  always_comb begin
    state_d = state;
    cnt_d   = cnt;
    case (state)
      PH_IDLE: if (req_valid) begin
        if (have_prev && (last_write != req_write)) begin
          state_d = PH_TURN;
          cnt_d   = CNT_W'(turn);
        end else begin
          state_d = PH_SETUP;
          cnt_d   = CNT_W'(sel_t.setup);
        end
      end
      PH_TURN: if (cnt == '0) begin
        state_d = PH_SETUP;
        cnt_d   = CNT_W'(cur_t.setup);
      end else cnt_d = cnt - 1'b1;
      PH_SETUP: if (cnt == '0) begin
        state_d = PH_STROBE;
        cnt_d   = CNT_W'(cur_t.strobe);
      end else cnt_d = cnt - 1'b1;
      PH_STROBE: if (cnt == '0) begin
        state_d = PH_HOLD;
        cnt_d   = CNT_W'(cur_t.hold);
      end else cnt_d = cnt - 1'b1;
      PH_HOLD: if (cnt == '0) state_d = PH_IDLE;
               else cnt_d = cnt - 1'b1;
      default: state_d = PH_IDLE;
    endcase
  end

  assign in_acc_d = (state_d == PH_SETUP) || (state_d == PH_STROBE) || (state_d == PH_HOLD);
  assign wr_d     = accept ? req_write : op_write;
  assign cle_d    = accept ? req_sel[0] : op_cle;
  assign ale_d    = accept ? (req_sel[1] & ~req_sel[0]) : op_ale;
  assign wdata_d  = accept ? req_wdata : op_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= PH_IDLE;
      cnt        <= '0;
      cur_t      <= '0;
      op_write   <= 1'b0;
      op_cle     <= 1'b0;
      op_ale     <= 1'b0;
      op_wdata   <= '0;
      have_prev  <= 1'b0;
      last_write <= 1'b0;
      busy       <= 1'b0;
      done       <= 1'b0;
      rdata      <= '0;
      nand_ce_n  <= 1'b1;
      nand_cle   <= 1'b0;
      nand_ale   <= 1'b0;
      nand_we_n  <= 1'b1;
      nand_re_n  <= 1'b1;
      nand_dout  <= '0;
      nand_doe   <= 1'b0;
    end else begin
      state    <= state_d;
      cnt      <= cnt_d;
      op_write <= wr_d;
      op_cle   <= cle_d;
      op_ale   <= ale_d;
      op_wdata <= wdata_d;
      if (accept) begin
        cur_t      <= sel_t;
        have_prev  <= 1'b1;
        last_write <= req_write;
      end
      if ((state == PH_STROBE) && (cnt == '0) && !op_write) rdata <= nand_din;
      done      <= (state == PH_HOLD) && (cnt == '0);
      busy      <= (state_d != PH_IDLE);
      nand_ce_n <= !in_acc_d;
      nand_cle  <= in_acc_d && cle_d;
      nand_ale  <= in_acc_d && ale_d;
      nand_we_n <= !((state_d == PH_STROBE) && wr_d);
      nand_re_n <= !((state_d == PH_STROBE) && !wr_d);
      nand_doe  <= in_acc_d && wr_d;
      nand_dout <= wdata_d;
    end
  end
endmodule

// File: rtl/nand_strobe_seq.sv
module nand_strobe_seq
  import nand_seq_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [31:0]       cfg_word,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_sel,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              dev_ready,
  output logic              nand_ce_n,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic [DATA_W-1:0] nand_dout,
  output logic              nand_doe,
  input  logic [DATA_W-1:0] nand_din,
  input  logic              nand_rdy
);
  acc_timing_t       wr_t, rd_t;
  logic [TURN_W-1:0] turn;

  nand_cfg_decode u_dec (
    .cfg_word(cfg_word), .wr_t(wr_t), .rd_t(rd_t), .turn(turn)
  );

  nand_phase_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst), .wr_t(wr_t), .rd_t(rd_t), .turn(turn),
    .req_valid(req_valid), .req_write(req_write), .req_sel(req_sel),
    .req_wdata(req_wdata), .nand_din(nand_din), .busy(busy), .done(done),
    .rdata(rdata), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
    .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
    .nand_dout(nand_dout), .nand_doe(nand_doe)
  );

  nand_rdy_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(nand_rdy), .dout(dev_ready)
  );
endmodule

// File: rtl/nand_strobe_seq_chk.sv
module nand_strobe_seq_chk (
  input logic clk,
  input logic rst,
  input logic nand_ce_n,
  input logic nand_we_n,
  input logic nand_re_n,
  input logic nand_cle,
  input logic nand_ale,
  input logic nand_doe,
  input logic done
);
  assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (rst)
    !(!nand_we_n && !nand_re_n));

  assert_strobe_in_ce_R11: assert property (@(posedge clk) disable iff (rst)
    nand_ce_n |-> (nand_we_n && nand_re_n));

  assert_latch_excl_R6: assert property (@(posedge clk) disable iff (rst)
    !(nand_cle && nand_ale));

  assert_latch_stable_R6: assert property (@(posedge clk) disable iff (rst)
    (!nand_ce_n && $past(!nand_ce_n)) |-> ($stable(nand_cle) && $stable(nand_ale)));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    nand_ce_n |-> (!nand_cle && !nand_ale && !nand_doe));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_after_access_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(!nand_ce_n));
endmodule

bind nand_strobe_seq nand_strobe_seq_chk u_chk (
  .clk(clk), .rst(rst), .nand_ce_n(nand_ce_n), .nand_we_n(nand_we_n),
  .nand_re_n(nand_re_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
  .nand_doe(nand_doe), .done(done)
);

// File: tb/nand_strobe_seq_bench.sv
module nand_strobe_seq_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic       w;
    logic       cle;
    logic       ale;
    logic [7:0] wd;
    logic [7:0] rd;
    logic [7:0] pre;
    logic [7:0] stb;
    logic [7:0] post;
    logic [7:0] gap;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] cfg_word = '0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_sel = '0;
  logic [7:0]  req_wdata = '0, rd_val = '0;
  logic        busy, done, dev_ready;
  logic [7:0]  rdata, nand_dout, nand_din;
  logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_doe;
  logic        nand_rdy = 1'b0;

  int nvec = 0, nbad = 0;
  int c_ws, c_wst, c_wh, c_rs, c_rst, c_rh, c_ta;
  logic prev_w = 1'b0, b2b = 1'b0, first_acc = 1'b1;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign nand_din = nand_re_n ? 8'h00 : rd_val;

  nand_strobe_seq u_nand_strobe_seq (
    .clk(clk), .rst(rst), .cfg_word(cfg_word), .req_valid(req_valid),
    .req_write(req_write), .req_sel(req_sel), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rdata(rdata), .dev_ready(dev_ready),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dout(nand_dout),
    .nand_doe(nand_doe), .nand_din(nand_din), .nand_rdy(nand_rdy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(input int ws, wst, wh, rs, rs2, rh, ta, input logic [31:0] extra);
    c_ws = ws; c_wst = wst; c_wh = wh; c_rs = rs; c_rst = rs2; c_rh = rh; c_ta = ta;
    cfg_word = (32'(ws) << 26) | (32'(wst) << 20) | (32'(wh) << 17) | (32'(rs) << 13)
             | (32'(rs2) << 7) | (32'(rh) << 4) | (32'(ta) << 2) | extra;
    b2b = 1'b0;
  endtask

  // driver: called on a negedge; issues one request and queues its expectation
  task automatic do_acc(input logic w, input logic [1:0] sel, input logic [7:0] d);
    exp_t e;
    while (busy) @(negedge clk);
    e.w   = w;
    e.cle = sel[0];
    e.ale = sel[1] & ~sel[0];
    e.wd  = w ? d : 8'h00;
    e.rd  = w ? 8'h00 : d;
    e.pre  = 8'(w ? c_ws + 1 : c_rs + 1);
    e.stb  = 8'(w ? c_wst + 1 : c_rst + 1);
    e.post = 8'(w ? c_wh + 1 : c_rh + 1);
    e.gap  = !b2b ? 8'hFF : ((prev_w != w) ? 8'(c_ta + 2) : 8'd1);
    q.push_back(e);
    if (!w) rd_val = d;
    req_write = w; req_sel = sel; req_wdata = d; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R8 busy after accept", int'(busy), 1);
    if (first_acc) chk(nand_ce_n == 1'b0, "R7 no gap before first access", int'(nand_ce_n), 0);
    first_acc = 1'b0;
    prev_w = w;
    b2b = 1'b1;
  endtask

  // monitor / scoreboard
  int m_pre = 0, m_stb = 0, m_post = 0, m_idle = 0, m_gap = -1;
  logic m_in = 1'b0, m_seen = 1'b0, m_cle, m_ale, m_doe_ok, m_dout_ok;
  always @(negedge clk) begin
    if (rst) begin
      m_in = 1'b0; m_seen = 1'b0; m_idle = 0;
    end else if (!nand_ce_n) begin
      if (!m_in) begin
        m_in = 1'b1; m_pre = 0; m_stb = 0; m_post = 0;
        m_gap = m_seen ? m_idle : -1;
        m_cle = nand_cle; m_ale = nand_ale;
        m_doe_ok = 1'b1; m_dout_ok = 1'b1;
      end
      if (!nand_we_n || !nand_re_n) m_stb++;
      else if (m_stb == 0) m_pre++;
      else m_post++;
      if (q.size() > 0) begin
        if (nand_doe != q[0].w) m_doe_ok = 1'b0;
        if (q[0].w && nand_dout != q[0].wd) m_dout_ok = 1'b0;
        if (q[0].w ? !nand_re_n : !nand_we_n) m_stb = 999;
      end
    end else begin
      if (m_in) begin
        exp_t e;
        m_in = 1'b0; m_seen = 1'b1; m_idle = 0;
        if (q.size() == 0) chk(1'b0, "R8 unexpected access", 1, 0);
        else begin
          e = q.pop_front();
          chk(m_pre == int'(e.pre), e.w ? "R2 write setup" : "R3 read setup", m_pre, int'(e.pre));
          chk(m_stb == int'(e.stb), e.w ? "R2 write strobe" : "R3 read strobe", m_stb, int'(e.stb));
          chk(m_post == int'(e.post), e.w ? "R2 write hold" : "R3 read hold", m_post, int'(e.post));
          chk(m_cle == e.cle, "R6 cle", int'(m_cle), int'(e.cle));
          chk(m_ale == e.ale, "R6 ale", int'(m_ale), int'(e.ale));
          chk(done == 1'b1, "R8 done after hold", int'(done), 1);
          chk(m_doe_ok, "R5 output enable", int'(m_doe_ok), 1);
          if (e.w) chk(m_dout_ok, "R5 write data", int'(m_dout_ok), 1);
          else chk(rdata == e.rd, "R4 read capture", int'(rdata), int'(e.rd));
          if (e.gap != 8'hFF) chk(m_gap == int'(e.gap), "R7 turnaround gap", m_gap, int'(e.gap));
        end
      end else if (done) chk(1'b0, "R8 stray done", 1, 0);
      m_idle++;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    nbad++; nvec++;
    $display("FAIL watchdog expired R8 actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    set_cfg(1, 3, 1, 1, 5, 1, 3, 32'h0);
    repeat (4) @(negedge clk);
    chk(nand_ce_n && nand_we_n && nand_re_n, "R1 strobes idle in reset", int'(nand_ce_n), 1);
    chk(!nand_cle && !nand_ale && !nand_doe, "R1 latches low in reset", int'(nand_cle), 0);
    chk(!busy && !done, "R1 busy/done low in reset", int'(busy), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(nand_ce_n && !busy && !done, "R1 idle after reset", int'(nand_ce_n), 1);

    // example programming
    do_acc(1'b1, 2'b01, 8'h70);
    do_acc(1'b1, 2'b10, 8'h12);
    do_acc(1'b1, 2'b00, 8'hA5);
    do_acc(1'b0, 2'b00, 8'h3C);
    do_acc(1'b0, 2'b00, 8'hC3);
    do_acc(1'b1, 2'b11, 8'h90);
    do_acc(1'b0, 2'b10, 8'h5A);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);

    // all-zero timing
    set_cfg(0, 0, 0, 0, 0, 0, 0, 32'h0);
    do_acc(1'b0, 2'b00, 8'h81);
    do_acc(1'b1, 2'b01, 8'hFF);
    do_acc(1'b1, 2'b00, 8'h01);
    do_acc(1'b0, 2'b11, 8'h7E);
    do_acc(1'b0, 2'b00, 8'h24);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);

    // R10: large fields with the ignored bits all set
    set_cfg(15, 63, 7, 9, 40, 5, 2, 32'hC000_0003);
    do_acc(1'b1, 2'b10, 8'h66);
    do_acc(1'b0, 2'b00, 8'h99);
    do_acc(1'b0, 2'b01, 8'hE1);
    do_acc(1'b1, 2'b00, 8'h1E);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);

    // R9: ready synchroniser depth
    nand_rdy = 1'b1;
    @(negedge clk);
    chk(dev_ready == 1'b0, "R9 ready after one edge", int'(dev_ready), 0);
    @(negedge clk);
    chk(dev_ready == 1'b1, "R9 ready after two edges", int'(dev_ready), 1);
    nand_rdy = 1'b0;
    @(negedge clk);
    chk(dev_ready == 1'b1, "R9 busy after one edge", int'(dev_ready), 1);
    @(negedge clk);
    chk(dev_ready == 1'b0, "R9 busy after two edges", int'(dev_ready), 0);

    repeat (2) @(negedge clk);
    chk(q.size() == 0, "R8 all accesses completed", q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule